// File: doc/BRIEF.md
# Multi-Mode QPSK Digital Modulator

The block turns a serial bit stream into a sampled quadrature phase-shift-keyed waveform. Bits arrive on a single data line and count only on cycles where a bit strobe is high. Strobed bits are taken in pairs. The earlier bit of a pair drives the in-phase branch and the later bit drives the quadrature branch. Each branch turns its bit into a level of +1 or -1 and multiplies that level by its own carrier sample: cosine for in-phase and sine for quadrature. The sum of the two branch products is the signed output sample. The carrier comes from a 32-step table that is built from one quarter of a sine wave. It advances one step on every clock.

A two-bit mode input selects one of three schemes. Plain QPSK lets both branches change together, so a symbol change can swing the phase by 180 degrees. The offset scheme delays the quadrature branch by one bit period. A single update then moves the phase by at most 90 degrees. The rotated scheme shifts the carrier by 45 degrees on every other symbol, so consecutive symbols come from two constellations offset by 45 degrees and no transition passes through the origin. Pulse shaping, conversion to analog and demodulation belong to other blocks.

Top module: `qpsk_mod`

## Requirements
- R1: A synchronous reset clears the output to 0, the carrier phase to step 0 and the bit-pair counter. The output stays 0 until one clock after the edge that captures the second bit of the first pair.
- R2: A bit is accepted only on a rising edge where `bit_stb` is 1. The first accepted bit of a pair becomes the in-phase bit. The in-phase bit does not change when that first bit is taken, and `bit_in` has no effect while `bit_stb` is 0.
- R3: A bit value of 1 maps to +1 and 0 maps to -1. The output equals bI*C(p) + bQ*S(p), where S(k) = round(127*sin(2*pi*k/32)), C(k) = S(k+8 mod 32), and p is the carrier step in use.
- R4: The carrier step counts rising edges since reset was released, modulo 32. The sample present after an edge uses the step, bits and mode held before that edge, so the output has one clock of latency.
- R5: With `mode` = 0 (plain), both branch bits take the new pair's values at the edge that captures the pair's second bit.
- R6: With `mode` = 1 (offset), the in-phase bit updates at the pair-completing edge. The quadrature bit takes that pair's second bit at the next accepted strobe, which is one bit period later. After reset the quadrature bit holds 0 until the first such update.
- R7: With `mode` = 2 (rotated), the carrier step in use is the counted step plus 4 (45 degrees) on the 2nd, 4th, 6th and later even-numbered completed pairs since reset. The step is unshifted on the odd-numbered pairs.
- R8: `mode` = 3 behaves exactly like `mode` = 0.
- R9: The output magnitude never exceeds 254.
- R10: A reset that arrives after the first bit of a pair discards that bit. The next accepted bit starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_stb | input | 1 | Bit-rate strobe; the bit is accepted on edges where this is 1 |
| mode | input | 2 | 0 plain, 1 offset, 2 rotated, 3 plain |
| sample_out | output | 10 | Signed modulated sample |

## Verification
Every result is due one clock after the edge that registers the state it depends on. A pair completed at edge n first appears in the sample present after edge n+1. In offset mode the delayed quadrature update appears one clock after the next strobe edge. The bench keeps its own model of the phase count and the captured bits. It advances that model on each rising edge and computes the sample due after that edge from the model state held before it. It then compares that sample with the output on the following falling edge, so no comparison can land on the wrong cycle.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;

    localparam int CAR_W      = 8;
    localparam int OUT_W      = 10;
    localparam int PH_W       = 5;
    localparam int QB         = PH_W - 2;
    localparam int QTR_STEPS  = 1 << QB;
    localparam int ROT_STEPS  = QTR_STEPS / 2;
    localparam int PEAK       = 2 * ((1 << (CAR_W - 1)) - 1);

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_OFFS  = 2'd1,
        MODE_ROT   = 2'd2,
        MODE_ALT   = 2'd3
    } mode_e;

    typedef struct packed {
        logic half;
        logic first;
        logic i_b;
        logic q_b;
        logic q_pend;
        logic q_due;
        logic tilt;
        logic active;
    } pair_s;

    localparam pair_s PAIR_RST = '{half: 1'b0, first: 1'b0, i_b: 1'b0, q_b: 1'b0,
                                   q_pend: 1'b0, q_due: 1'b0, tilt: 1'b1, active: 1'b0};

    function automatic logic signed [CAR_W-1:0] qtr_mag(input logic [QB:0] m);
        case (int'(m))
            0:       return CAR_W'(0);
            1:       return CAR_W'(25);
            2:       return CAR_W'(49);
            3:       return CAR_W'(71);
            4:       return CAR_W'(90);
            5:       return CAR_W'(106);
            6:       return CAR_W'(117);
            7:       return CAR_W'(125);
            default: return CAR_W'(127);
        endcase
    endfunction

    function automatic logic signed [CAR_W-1:0] wave_at(input logic [PH_W-1:0] p);
        logic [QB:0]              m;
        logic signed [CAR_W-1:0]  mag;
        m   = p[QB] ? ((QB+1)'(QTR_STEPS) - {1'b0, p[QB-1:0]}) : {1'b0, p[QB-1:0]};
        mag = qtr_mag(m);
        return p[QB+1] ? -mag : mag;
    endfunction

endpackage

// File: rtl/qpsk_pair.sv
module qpsk_pair
    import qpsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_in,
    input  logic  bit_stb,
    input  mode_e mode,
    output logic  i_bit,
    output logic  q_bit,
    output logic  rot_en,
    output logic  active
);

    pair_s pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (bit_stb) begin
            if (!pr_q.half) begin
                pr_d.half  = 1'b1;
                pr_d.first = bit_in;
                if (pr_q.q_due) begin
                    pr_d.q_b   = pr_q.q_pend;
                    pr_d.q_due = 1'b0;
                end
            end else begin
                pr_d.half   = 1'b0;
                pr_d.i_b    = pr_q.first;
                pr_d.active = 1'b1;
                pr_d.tilt   = ~pr_q.tilt;
                if (mode == MODE_OFFS) begin
                    pr_d.q_pend = bit_in;
                    pr_d.q_due  = 1'b1;
                end else begin
                    pr_d.q_b   = bit_in;
                    pr_d.q_due = 1'b0;
                end
            end
        end
        if (rst) begin
            pr_d = PAIR_RST;
        end
    end

    always_ff @(posedge clk) begin
        pr_q <= pr_d;
    end

    assign i_bit  = pr_q.i_b;
    assign q_bit  = pr_q.q_b;
    assign active = pr_q.active;
    assign rot_en = (mode == MODE_ROT) && pr_q.tilt;

    AST_I_HOLD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !pr_q.half) |=> $stable(pr_q.i_b)); // R2

    AST_CONV_Q_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && pr_q.half && mode == MODE_PLAIN) |=> (pr_q.q_b == $past(bit_in))); // R5

    AST_OFFS_Q_DELAY: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && pr_q.half && mode == MODE_OFFS) |=> $stable(pr_q.q_b)); // R6

    AST_TILT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && pr_q.half) |=> (pr_q.tilt != $past(pr_q.tilt))); // R7

endmodule

// File: rtl/qpsk_nco.sv
module qpsk_nco
    import qpsk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rot_en,
    output logic signed [CAR_W-1:0] cos_o,
    output logic signed [CAR_W-1:0] sin_o
);

    logic [PH_W-1:0]         ph_d, ph_q;
    logic [PH_W-1:0]         base;
    logic signed [CAR_W-1:0] tap [2];

    always_comb begin
        ph_d = ph_q + PH_W'(1);
        if (rst) begin
            ph_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ph_q <= ph_d;
    end

    assign base = ph_q + (rot_en ? PH_W'(ROT_STEPS) : PH_W'(0));

    for (genvar g = 0; g < 2; g++) begin : g_tap
        logic [PH_W-1:0] idx;
        assign idx    = base + PH_W'(g * QTR_STEPS);
        assign tap[g] = wave_at(idx);
    end

    assign sin_o = tap[0];
    assign cos_o = tap[1];

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ph_q == $past(ph_q) + PH_W'(1))); // R4

endmodule

// File: rtl/qpsk_mixer.sv
module qpsk_mixer
    import qpsk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_bit,
    input  logic                    q_bit,
    input  logic                    active,
    input  logic signed [CAR_W-1:0] cos_i,
    input  logic signed [CAR_W-1:0] sin_i,
    output logic signed [OUT_W-1:0] sample_o
);

    logic signed [OUT_W-1:0] cos_x, sin_x, i_prod, q_prod;
    logic signed [OUT_W-1:0] out_d, out_q;

    assign cos_x = OUT_W'(cos_i);
    assign sin_x = OUT_W'(sin_i);

    always_comb begin
        i_prod = i_bit ? cos_x : -cos_x;
        q_prod = q_bit ? sin_x : -sin_x;
        out_d  = active ? (i_prod + q_prod) : '0;
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign sample_o = out_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> (out_q == '0)); // R1

    AST_SWING_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (int'(out_q) <= PEAK) && (int'(out_q) >= -PEAK)); // R9

endmodule

// File: rtl/qpsk_mod.sv
module qpsk_mod
    import qpsk_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    input  logic                    bit_stb,
    input  logic [1:0]              mode,
    output logic signed [OUT_W-1:0] sample_out
);

    logic                    i_bit, q_bit, rot_en, active;
    logic signed [CAR_W-1:0] cos_s, sin_s;

    qpsk_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_stb (bit_stb),
        .mode    (mode_e'(mode)),
        .i_bit   (i_bit),
        .q_bit   (q_bit),
        .rot_en  (rot_en),
        .active  (active)
    );

    qpsk_nco u_nco (
        .clk    (clk),
        .rst    (rst),
        .rot_en (rot_en),
        .cos_o  (cos_s),
        .sin_o  (sin_s)
    );

    qpsk_mixer u_mix (
        .clk      (clk),
        .rst      (rst),
        .i_bit    (i_bit),
        .q_bit    (q_bit),
        .active   (active),
        .cos_i    (cos_s),
        .sin_i    (sin_s),
        .sample_o (sample_out)
    );

endmodule

// File: tb/qpsk_mod_test.sv
`timescale 1ns/1ps
module qpsk_mod_test;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bit_in = 1'b0;
    logic              bit_stb = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic signed [9:0] sample_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_en  = 1'b0;
    bit    done    = 1'b0;
    string seg     = "R1";

    // reference model state
    int m_ph = 0;
    bit m_half = 0, m_first = 0, m_i = 0, m_q = 0, m_pend = 0, m_due = 0;
    bit m_tilt = 1, m_act = 0;
    int exp_s = 0;

    always #2.5 clk = ~clk;

    qpsk_mod uut (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_stb    (bit_stb),
        .mode       (mode),
        .sample_out (sample_out)
    );

    function automatic int car(input int k);
        real r;
        r = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k % 32) / 32.0);
        if (r >= 0.0) return $rtoi($floor(r + 0.5));
        return -$rtoi($floor(-r + 0.5));
    endfunction

    function automatic int ref_out(input bit bi, input bit bq, input int p);
        int si, sq;
        si = bi ? 1 : -1;
        sq = bq ? 1 : -1;
        return si * car(p + 8) + sq * car(p);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_s = 0; m_ph = 0; m_half = 0; m_first = 0; m_i = 0; m_q = 0;
            m_pend = 0; m_due = 0; m_tilt = 1; m_act = 0;
        end else begin
            exp_s = m_act ? ref_out(m_i, m_q, m_ph + ((mode == 2'd2 && m_tilt) ? 4 : 0)) : 0;
            m_ph = (m_ph + 1) % 32;
            if (bit_stb) begin
                if (!m_half) begin
                    m_half = 1; m_first = bit_in;
                    if (m_due) begin m_q = m_pend; m_due = 0; end
                end else begin
                    m_half = 0; m_i = m_first; m_act = 1; m_tilt = ~m_tilt;
                    if (mode == 2'd1) begin m_pend = bit_in; m_due = 1; end
                    else begin m_q = bit_in; m_due = 0; end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_tests++;
            if (int'(sample_out) != exp_s) begin
                n_fail++;
                $display("FAIL %s sample: actual %0d expected %0d at %0t", seg, sample_out, exp_s, $time);
            end
            n_tests++;
            if (int'(sample_out) > 254 || int'(sample_out) < -254) begin
                n_fail++;
                $display("FAIL R9 magnitude: actual %0d expected within 254", sample_out);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_stb = 1'b0;
            bit_in  = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic send_bit(input bit b, input int gap);
        @(negedge clk);
        bit_in  = b;
        bit_stb = 1'b1;
        idle(gap - 1);
        if (gap == 1) begin
            @(negedge clk);
            bit_stb = 1'b0;
            bit_in  = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        bit_stb = 1'b0;
        for (int k = 0; k < n; k++) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic random_bits(input int n, input int max_gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_in  = 1'($urandom_range(0, 1));
            bit_stb = 1'b1;
            for (int g = 1; g < int'($urandom_range(1, max_gap)); g++) begin
                @(negedge clk);
                bit_stb = 1'b0;
                bit_in  = 1'($urandom_range(0, 1));
            end
        end
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        chk_en = 1'b1;
        // R1: reset state and silence before a full pair
        seg = "R1";
        do_reset(3);
        send_bit(1'b1, 3);
        idle(8);
        // R2: bits without strobe are ignored
        seg = "R2";
        send_bit(1'b0, 2);
        send_bit(1'b1, 2);
        idle(40);
        // R3: each of the four bit pairs held over full carrier cycles
        seg = "R3";
        send_bit(1'b1, 40); send_bit(1'b0, 40);
        send_bit(1'b0, 40); send_bit(1'b1, 40);
        send_bit(1'b0, 40); send_bit(1'b0, 40);
        send_bit(1'b1, 40); send_bit(1'b1, 40);
        // R4: phase keeps running with a steady symbol
        seg = "R4";
        idle(70);
        // R5: plain mode, random bits, back-to-back and spaced strobes
        seg = "R5";
        random_bits(200, 4);
        random_bits(60, 1);
        // R6: offset mode
        seg = "R6";
        mode = 2'd1;
        do_reset(2);
        send_bit(1'b1, 3); send_bit(1'b1, 3);
        idle(6);
        random_bits(200, 4);
        random_bits(60, 1);
        // R7: rotated mode
        seg = "R7";
        mode = 2'd2;
        do_reset(2);
        send_bit(1'b1, 20); send_bit(1'b1, 20);
        send_bit(1'b1, 20); send_bit(1'b1, 20);
        random_bits(200, 4);
        // R8: reserved code acts as plain
        seg = "R8";
        mode = 2'd3;
        do_reset(2);
        random_bits(120, 3);
        // R10: reset mid-pair drops the half pair
        seg = "R10";
        mode = 2'd0;
        do_reset(2);
        send_bit(1'b0, 3);
        do_reset(1);
        send_bit(1'b1, 10); send_bit(1'b0, 10);
        idle(20);
        random_bits(40, 3);
        idle(10);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL %s watchdog: actual %0d cycles expected fewer", seg, 100000);
            summary();
            $finish;
        end
    end

endmodule